// File: doc/BRIEF.md
# Turn-Model Mesh Route Computation

This unit picks the output port for a head flit arriving at one router of a two-dimensional mesh. It compares the router's own coordinates with the destination coordinates carried by the flit and works out which directions bring the packet closer (the productive directions). It then removes the directions that the selected turn-model algorithm forbids and returns one port: East, West, North, South or Local.

A static two-bit input selects the algorithm: dimension order (X first, then Y), west-first, north-last or negative-first. In the three adaptive algorithms, two productive directions can both be legal. In that case the unit reads a congestion level per output port, taken from local state such as downstream buffer occupancy, and sends the flit toward the less loaded one.

The result is registered one cycle after the head flit is presented. It holds until the next head flit arrives, so the switch allocator can use it for the body and tail flits that follow.

Top module: `mesh_route_unit`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `route_valid` is 0 and `route_port` is Local (code 0).
- R2: A cycle with `head_valid` high gives `route_valid` high on the next cycle, with the computed port on `route_port`. A cycle with `head_valid` low gives `route_valid` low on the next cycle, and `route_port` keeps its previous value. Port codes are: Local 0, East 1 (+x), West 2 (−x), North 3 (+y), South 4 (−y).
- R3: When the destination equals the current node, the port is Local in every algorithm.
- R4: Routing is minimal. East is chosen only if dst_x > cur_x, West only if dst_x < cur_x, North only if dst_y > cur_y, and South only if dst_y < cur_y.
- R5: With `alg_sel` = 0 (dimension order), the port is East or West while the X coordinates differ. North or South is chosen only once the X coordinates are equal.
- R6: With `alg_sel` = 1 (west-first), West is chosen whenever West is productive, whatever the congestion levels.
- R7: With `alg_sel` = 2 (north-last), North is never chosen while East or West is still productive. When North is the only productive direction, North is chosen.
- R8: With `alg_sel` = 3 (negative-first), the port is West or South whenever either of them is productive. West with North gives West, and East with South gives South.
- R9: When two productive directions are both legal, the one with the strictly lower congestion level wins. On a tie, the X-dimension port wins. The `cong_lvl` field for East is bits [CW-1:0], West is [2CW-1:CW], North is [3CW-1:2CW] and South is [4CW-1:3CW].
- R10: When only one legal productive direction exists, the congestion levels have no effect on the port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alg_sel | input | 2 | Static algorithm select (0 XY, 1 west-first, 2 north-last, 3 negative-first) |
| cur_x | input | XW | This router's X coordinate |
| cur_y | input | YW | This router's Y coordinate |
| head_valid | input | 1 | A head flit is present this cycle |
| dst_x | input | XW | Destination X from the head flit |
| dst_y | input | YW | Destination Y from the head flit |
| cong_lvl | input | 4*CW | Congestion level per output (E, W, N, S from the low bits up) |
| route_valid | output | 1 | Route result updated this cycle |
| route_port | output | 3 | Selected output port code |

## Verification
If the productive mask or the turn filter goes wrong, the result is a port that points away from the destination or breaks a turn rule. That wrong port shows on `route_port` in the cycle right after the head flit. It is caught by comparing against a behavioural model on every clock. If the selection tie-break or the comparison direction is wrong, only congested pairs of legal ports show the error, so the stimulus uses deliberate ties and unequal congestion levels in every adaptive algorithm. If the hold register is wrong, `route_port` changes during cycles without a head flit, which the model flags at once.

// File: rtl/route_pkg.sv
package route_pkg;
  localparam int NPORT = 5;

  typedef enum logic [2:0] {
    PORT_LOCAL = 3'd0,
    PORT_EAST  = 3'd1,
    PORT_WEST  = 3'd2,
    PORT_NORTH = 3'd3,
    PORT_SOUTH = 3'd4
  } port_e;

  typedef enum logic [1:0] {
    ALG_XY         = 2'd0,
    ALG_WEST_FIRST = 2'd1,
    ALG_NORTH_LAST = 2'd2,
    ALG_NEG_FIRST  = 2'd3
  } alg_e;

  typedef logic [NPORT-1:0] pmask_t;
endpackage

// File: rtl/route_productive.sv
module route_productive
  import route_pkg::*;
#(
  parameter int XW = 3,
  parameter int YW = 3
) (
  input  logic [XW-1:0] cur_x,
  input  logic [YW-1:0] cur_y,
  input  logic [XW-1:0] dst_x,
  input  logic [YW-1:0] dst_y,
  output pmask_t        prod
);
  always_comb begin
    prod             = '0;
    prod[PORT_EAST]  = (dst_x > cur_x);
    prod[PORT_WEST]  = (dst_x < cur_x);
    prod[PORT_NORTH] = (dst_y > cur_y);
    prod[PORT_SOUTH] = (dst_y < cur_y);
    prod[PORT_LOCAL] = (dst_x == cur_x) && (dst_y == cur_y);
  end
endmodule

// File: rtl/route_turn_filter.sv
module route_turn_filter
  import route_pkg::*;
(
  input  logic [1:0] alg_sel,
  input  pmask_t     prod,
  output pmask_t     legal
);
  logic x_open;
  assign x_open = prod[PORT_EAST] | prod[PORT_WEST];

  always_comb begin
    legal = prod;
    unique case (alg_e'(alg_sel))
      ALG_XY: begin
        if (x_open) begin
          legal[PORT_NORTH] = 1'b0;
          legal[PORT_SOUTH] = 1'b0;
        end
      end
      ALG_WEST_FIRST: begin
        if (prod[PORT_WEST]) begin
          legal = '0;
          legal[PORT_WEST] = 1'b1;
        end
      end
      ALG_NORTH_LAST: begin
        if (prod[PORT_NORTH] && x_open) legal[PORT_NORTH] = 1'b0;
      end
      ALG_NEG_FIRST: begin
        if (prod[PORT_WEST] | prod[PORT_SOUTH]) begin
          legal[PORT_EAST]  = 1'b0;
          legal[PORT_NORTH] = 1'b0;
        end
      end
      default: legal = prod;
    endcase
  end
endmodule

// File: rtl/route_select.sv
module route_select
  import route_pkg::*;
#(
  parameter int CW = 4
) (
  input  pmask_t          legal,
  input  logic [4*CW-1:0] cong_lvl,
  output logic [2:0]      port
);
  localparam int NDIR = 4;
  logic [CW-1:0] lvl [NDIR];

  genvar g;
  generate
    for (g = 0; g < NDIR; g++) begin : g_unpack
      assign lvl[g] = cong_lvl[g*CW +: CW];
    end
  endgenerate

  logic          has_x, has_y;
  logic [2:0]    x_port, y_port;
  logic [CW-1:0] x_lvl, y_lvl;

  always_comb begin
    has_x  = legal[PORT_EAST] | legal[PORT_WEST];
    has_y  = legal[PORT_NORTH] | legal[PORT_SOUTH];
    x_port = legal[PORT_EAST]  ? PORT_EAST  : PORT_WEST;
    y_port = legal[PORT_NORTH] ? PORT_NORTH : PORT_SOUTH;
    x_lvl  = legal[PORT_EAST]  ? lvl[0] : lvl[1];
    y_lvl  = legal[PORT_NORTH] ? lvl[2] : lvl[3];
    if (has_x && has_y)  port = (y_lvl < x_lvl) ? y_port : x_port;
    else if (has_x)      port = x_port;
    else if (has_y)      port = y_port;
    else                 port = PORT_LOCAL;
  end
endmodule

// File: rtl/mesh_route_unit.sv
module mesh_route_unit
  import route_pkg::*;
#(
  parameter int XW = 3,
  parameter int YW = 3,
  parameter int CW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      alg_sel,
  input  logic [XW-1:0]   cur_x,
  input  logic [YW-1:0]   cur_y,
  input  logic            head_valid,
  input  logic [XW-1:0]   dst_x,
  input  logic [YW-1:0]   dst_y,
  input  logic [4*CW-1:0] cong_lvl,
  output logic            route_valid,
  output logic [2:0]      route_port
);
  pmask_t     prod, legal;
  logic [2:0] next_port;

  route_productive #(.XW(XW), .YW(YW)) u_prod (
    .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y), .prod(prod)
  );

  route_turn_filter u_filt (
    .alg_sel(alg_sel), .prod(prod), .legal(legal)
  );

  route_select #(.CW(CW)) u_sel (
    .legal(legal), .cong_lvl(cong_lvl), .port(next_port)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      route_valid <= 1'b0;
      route_port  <= PORT_LOCAL;
    end else begin
      route_valid <= head_valid;
      if (head_valid) route_port <= next_port;
    end
  end

  assert_head_latency_R2: assert property (@(posedge clk) disable iff (rst)
    head_valid |=> route_valid);
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !head_valid |=> (!route_valid && $stable(route_port)));
  assert_local_R3: assert property (@(posedge clk) disable iff (rst)
    route_valid && $past(dst_x == cur_x && dst_y == cur_y) |-> route_port == PORT_LOCAL);
  assert_min_east_R4: assert property (@(posedge clk) disable iff (rst)
    route_valid && route_port == PORT_EAST |-> $past(dst_x > cur_x));
  assert_min_west_R4: assert property (@(posedge clk) disable iff (rst)
    route_valid && route_port == PORT_WEST |-> $past(dst_x < cur_x));
  assert_min_north_R4: assert property (@(posedge clk) disable iff (rst)
    route_valid && route_port == PORT_NORTH |-> $past(dst_y > cur_y));
  assert_min_south_R4: assert property (@(posedge clk) disable iff (rst)
    route_valid && route_port == PORT_SOUTH |-> $past(dst_y < cur_y));
  assert_xy_order_R5: assert property (@(posedge clk) disable iff (rst)
    route_valid && $past(alg_sel == 2'd0 && dst_x != cur_x)
      |-> (route_port == PORT_EAST || route_port == PORT_WEST));
  assert_west_first_R6: assert property (@(posedge clk) disable iff (rst)
    route_valid && $past(alg_sel == 2'd1 && dst_x < cur_x) |-> route_port == PORT_WEST);
  assert_north_last_R7: assert property (@(posedge clk) disable iff (rst)
    route_valid && $past(alg_sel == 2'd2 && dst_x != cur_x) |-> route_port != PORT_NORTH);
  assert_neg_first_R8: assert property (@(posedge clk) disable iff (rst)
    route_valid && $past(alg_sel == 2'd3 && (dst_x < cur_x || dst_y < cur_y))
      |-> (route_port == PORT_WEST || route_port == PORT_SOUTH));
  assert_adapt_R9: assert property (@(posedge clk) disable iff (rst)
    route_valid && $past(alg_sel == 2'd1 && dst_x > cur_x && dst_y > cur_y &&
                         cong_lvl[3*CW-1:2*CW] < cong_lvl[CW-1:0])
      |-> route_port == PORT_NORTH);
endmodule

// File: tb/mesh_route_unit_tb.sv
module mesh_route_unit_tb;
  localparam int XW = 3, YW = 3, CW = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, head_valid, route_valid;
  logic [1:0] alg_sel;
  logic [XW-1:0] cur_x, dst_x;
  logic [YW-1:0] cur_y, dst_y;
  logic [4*CW-1:0] cong_lvl;
  logic [2:0] route_port;

  mesh_route_unit #(.XW(XW), .YW(YW), .CW(CW)) u_dut (
    .clk(clk), .rst(rst), .alg_sel(alg_sel), .cur_x(cur_x), .cur_y(cur_y),
    .head_valid(head_valid), .dst_x(dst_x), .dst_y(dst_y), .cong_lvl(cong_lvl),
    .route_valid(route_valid), .route_port(route_port)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  int exp_valid = 0, exp_port = 0;

  // behavioural model: signs of the offsets and the turn rule of each algorithm
  function automatic int model(int alg, int cx, int cy, int dx, int dy,
                               int ce, int cw, int cn, int cs);
    int sx, sy, xd, yd, xl, yl, pick;
    sx = (dx > cx) ? 1 : (dx < cx) ? -1 : 0;
    sy = (dy > cy) ? 1 : (dy < cy) ? -1 : 0;
    if (sx == 0 && sy == 0) return 0;
    xd = (sx > 0) ? 1 : 2;  xl = (sx > 0) ? ce : cw;
    yd = (sy > 0) ? 3 : 4;  yl = (sy > 0) ? cn : cs;
    if (sy == 0) return xd;
    if (sx == 0) return yd;
    pick = (yl < xl) ? yd : xd;
    case (alg)
      0: return xd;
      1: return (sx < 0) ? 2 : pick;
      2: return (sy > 0) ? xd : pick;
      default: begin
        if (sx < 0 && sy > 0) return 2;
        if (sx > 0 && sy < 0) return 4;
        return pick;
      end
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(string tag, int alg, int hv, int cx, int cy, int dx, int dy,
                       int ce, int cw, int cn, int cs);
    alg_sel = alg[1:0]; head_valid = hv[0];
    cur_x = cx[XW-1:0]; cur_y = cy[YW-1:0];
    dst_x = dx[XW-1:0]; dst_y = dy[YW-1:0];
    cong_lvl = {cs[CW-1:0], cn[CW-1:0], cw[CW-1:0], ce[CW-1:0]};
    exp_valid = hv;
    if (hv != 0) exp_port = model(alg, cx, cy, dx, dy, ce, cw, cn, cs);
    @(posedge clk);
    @(negedge clk);
    check({tag, " valid"}, int'(route_valid), exp_valid);
    check({tag, " port"}, int'(route_port), exp_port);
  endtask

  initial begin
    rst = 1'b1; head_valid = 1'b0; alg_sel = 2'd0;
    cur_x = '0; cur_y = '0; dst_x = '0; dst_y = '0; cong_lvl = '0;
    repeat (3) @(negedge clk);
    check("R1 reset valid", int'(route_valid), 0);
    check("R1 reset port", int'(route_port), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset port", int'(route_port), 0);

    apply("R5 xy east", 0, 1, 2, 2, 5, 5, 15, 0, 0, 0);
    apply("R5 xy south", 0, 1, 2, 2, 2, 0, 0, 0, 0, 0);
    apply("R10 xy cong ignored", 0, 1, 0, 0, 7, 7, 15, 0, 0, 0);
    apply("R3 local", 2, 1, 3, 3, 3, 3, 0, 0, 0, 0);
    apply("R2 hold", 2, 0, 1, 1, 6, 6, 0, 0, 0, 0);
    apply("R6 west first", 1, 1, 4, 1, 1, 6, 0, 15, 0, 0);
    apply("R9 wf lower north", 1, 1, 1, 1, 4, 4, 9, 0, 3, 0);
    apply("R9 wf tie east", 1, 1, 1, 1, 4, 4, 5, 0, 5, 0);
    apply("R7 nl x before north", 2, 1, 1, 1, 0, 5, 0, 15, 0, 0);
    apply("R7 nl north alone", 2, 1, 1, 1, 1, 5, 0, 0, 9, 0);
    apply("R9 nl south lower", 2, 1, 5, 5, 2, 1, 0, 7, 0, 2);
    apply("R8 nf west over north", 3, 1, 3, 3, 1, 6, 0, 15, 0, 0);
    apply("R8 nf south over east", 3, 1, 3, 3, 6, 0, 0, 0, 0, 15);
    apply("R9 nf north lower", 3, 1, 3, 3, 6, 6, 8, 0, 1, 0);
    apply("R3 local nf", 3, 1, 0, 7, 0, 7, 1, 1, 1, 1);

    for (int a = 0; a < 4; a++) begin
      for (int i = 0; i < 1500; i++) begin
        apply("R4 random", a, ($urandom_range(0, 9) < 7) ? 1 : 0,
              $urandom_range(0, 7), $urandom_range(0, 7),
              $urandom_range(0, 7), $urandom_range(0, 7),
              $urandom_range(0, 15), $urandom_range(0, 15),
              $urandom_range(0, 15), $urandom_range(0, 15));
      end
    end

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule